// File: doc/BRIEF.md
# Receive Elastic Buffer With Status

This block sits between a recovered receive clock and the local interface clock of a 16-bit, two-symbol-per-clock SuperSpeed receive path. An upstream 8b/10b decoder presents one word per write cycle. Each word is two decoded bytes with a per-byte data/control flag and per-byte decode-error and disparity-error flags. The buffer carries these words across the clock boundary through Gray-coded pointers. It hands them out one word per read cycle, together with a 3-bit status code.

The two clocks never match exactly, so the buffer keeps its fill near the middle. It does this only where a skip word sits at the head of the queue. A skip word is two control bytes of value 0x3C. When the buffer is too full, the skip word is dropped. When it is too empty, the skip word is sent twice. Every insertion, removal, overflow, underflow and upstream error is reported in the status field of the word it affects. When several events land on one word, a fixed priority picks the code. A parameter selects nominal-empty operation. In that mode, reading starts as soon as one word is held, skip words are never added, and no underflow code is produced.

Top module: `rx_elastic_buf`

## Requirements
- R1: Output data bits 7:0 hold the first received symbol and bits 15:8 the second, and non-skip words leave in the order they arrived.
- R2: Output flag bit 0 belongs to the low byte and bit 1 to the high byte. A 1 marks a control byte and a 0 a data byte. Each flag travels with its byte.
- R3: While the lock input is low, no word is stored. outValid is high only after lock has been held and a stored word is being delivered.
- R4: A word with a decode error on either byte is delivered with status 100.
- R5: A word with a disparity error on either byte, and no decode error, is delivered with status 111.
- R6: A skip word is both bytes 0x3C with both flags 1. When the read-side fill exceeds 20 symbols and a skip word is at the head, that skip word is discarded. The following word is delivered with status 010.
- R7: In half-full mode, when the read-side fill is below 12 symbols and a skip word is at the head, that skip word is delivered twice. The first copy has status 001.
- R8: A word that arrives while the buffer holds 32 symbols is discarded. The next stored word is delivered with status 101.
- R9: In half-full mode, if the buffer runs empty while delivering, that read cycle has outValid low and status 110. Delivery then pauses until the fill reaches 16 symbols again.
- R10: A delivered word with no event has status 000. Idle cycles show 000, except the underflow cycle of R9.
- R11: When one word has several events, the status follows this priority: decode error, then disparity error, then overflow or underflow, then skip add or remove.
- R12: With NOMINAL_EMPTY set, delivery starts once one word is held, skip words are never added, and status 110 never appears.
- R13: During and right after reset, outValid is 0 and the status is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Recovered receive clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| inValid | input | 1 | Input word present this write cycle |
| inLock | input | 1 | Symbol lock held by the upstream decoder |
| inData | input | 16 | Two decoded symbols, first in bits 7:0 |
| inK | input | 2 | Per-byte control flag |
| inDecErr | input | 2 | Per-byte 8b/10b decode error |
| inDispErr | input | 2 | Per-byte running-disparity error |
| rdClk | input | 1 | Local interface clock |
| outValid | output | 1 | Output word valid |
| outData | output | 16 | Two symbols, first in bits 7:0 |
| outK | output | 2 | Per-byte control flag of the output word |
| outStatus | output | 3 | Receive status code for the output word |

## Verification
The hardest states to reach are skip add and skip remove, because each needs a skip word at the head exactly while the synchronized fill sits past a threshold. The bench reaches them by running the write clock at a different rate from the read clock: 4 ns per write against 5 ns per read makes the fill climb, and 6 ns makes it sink. Skip words are placed every third word so that one soon reaches the head once the threshold is crossed. The same rate offsets with no skip words drive the buffer into overflow and underflow. A second instance in nominal-empty mode receives the same stimulus, so the absence of adds and underflow codes can be compared directly against the half-full instance.

// File: rtl/rx_elastic_buf_pkg.sv
package rx_elastic_buf_pkg;

  typedef enum logic [2:0] {
    ST_GOOD      = 3'b000,
    ST_SKP_ADD   = 3'b001,
    ST_SKP_DEL   = 3'b010,
    ST_DEC_ERR   = 3'b100,
    ST_OVERFLOW  = 3'b101,
    ST_UNDERFLOW = 3'b110,
    ST_DISP_ERR  = 3'b111
  } status_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrEn;     // store the input word (write domain)
    status_e wrCode;   // code stored with it
    logic    selNext;  // deliver the entry after the head (skip removal)
    logic    outValid; // delivered word valid (read domain)
    status_e outCode;  // status for the delivered cycle
  } strobe_t;

  function automatic logic [2:0] codeRank(input status_e c);
    case (c)
      ST_DEC_ERR:                return 3'd4;
      ST_DISP_ERR:               return 3'd3;
      ST_OVERFLOW, ST_UNDERFLOW: return 3'd2;
      ST_SKP_ADD, ST_SKP_DEL:    return 3'd1;
      default:                   return 3'd0;
    endcase
  endfunction

  // keep the higher-ranked code; an event of equal rank replaces the base
  function automatic status_e mergeCode(input status_e base, input status_e ev);
    return (codeRank(ev) >= codeRank(base)) ? ev : base;
  endfunction

endpackage

// File: rtl/rx_elastic_buf_dp.sv
module rx_elastic_buf_dp
  import rx_elastic_buf_pkg::*;
#(
  parameter int         DEPTH_W = 16,
  parameter int         AW      = 4,
  parameter logic [7:0] SKP_SYM = 8'h3C
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic [15:0]   inData,
  input  logic [1:0]    inK,
  input  strobe_t       str,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  output logic          headSkp,
  output status_e       headCode,
  output status_e       nextCode,
  output logic          outValid,
  output logic [15:0]   outData,
  output logic [1:0]    outK,
  output logic [2:0]    outStatus
);

  logic [15:0]   memData [DEPTH_W];
  logic [1:0]    memK    [DEPTH_W];
  status_e       memCode [DEPTH_W];
  logic [AW-1:0] nextAddr;

  always_ff @(posedge wrClk) begin
    if (str.wrEn) begin
      memData[wrAddr] <= inData;
      memK[wrAddr]    <= inK;
      memCode[wrAddr] <= str.wrCode;
    end
  end

  assign nextAddr = rdAddr + 1'b1;
  assign headSkp  = (memK[rdAddr] == 2'b11) && (memData[rdAddr] == {SKP_SYM, SKP_SYM});
  assign headCode = memCode[rdAddr];
  assign nextCode = memCode[nextAddr];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outK      <= '0;
      outStatus <= ST_GOOD;
    end else begin
      outValid  <= str.outValid;
      outStatus <= str.outCode;
      if (!str.outValid) begin
        outData <= '0;
        outK    <= '0;
      end else if (str.selNext) begin
        outData <= memData[nextAddr];
        outK    <= memK[nextAddr];
      end else begin
        outData <= memData[rdAddr];
        outK    <= memK[rdAddr];
      end
    end
  end

endmodule

// File: rtl/rx_elastic_buf_ctrl.sv
module rx_elastic_buf_ctrl
  import rx_elastic_buf_pkg::*;
#(
  parameter int DEPTH_W       = 16,
  parameter int AW            = 4,
  parameter int START_W       = 8,
  parameter int ADD_W         = 6,
  parameter int DROP_W        = 10,
  parameter bit NOMINAL_EMPTY = 1'b0
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inLock,
  input  logic [1:0]    inDecErr,
  input  logic [1:0]    inDispErr,
  input  logic          headSkp,
  input  status_e       headCode,
  input  status_e       nextCode,
  output strobe_t       str,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [AW:0]   wrFill,
  output logic          rdLock
);

  localparam logic [AW:0] FullLvl  = (AW+1)'(DEPTH_W);
  localparam logic [AW:0] StartLvl = (AW+1)'(START_W);
  localparam logic [AW:0] AddLvl   = (AW+1)'(ADD_W);
  localparam logic [AW:0] DropLvl  = (AW+1)'(DROP_W);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [AW:0] wrBin, wrBinNext, wrGray, rdGrayA, rdGrayB;
  logic        ovfPend, accept, isFull, doWrite;
  status_e     wrCode;

  always_comb begin
    wrFill    = wrBin - g2b(rdGrayB);
    isFull    = (wrFill == FullLvl);
    accept    = inValid && inLock;
    doWrite   = accept && !isFull;
    wrBinNext = wrBin + (AW+1)'(doWrite);
    if (|inDecErr)       wrCode = ST_DEC_ERR;
    else if (|inDispErr) wrCode = ST_DISP_ERR;
    else if (ovfPend)    wrCode = ST_OVERFLOW;
    else                 wrCode = ST_GOOD;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin   <= '0;
      wrGray  <= '0;
      rdGrayA <= '0;
      rdGrayB <= '0;
      ovfPend <= 1'b0;
    end else begin
      rdGrayA <= rdGray;
      rdGrayB <= rdGrayA;
      wrBin   <= wrBinNext;
      wrGray  <= wrBinNext ^ (wrBinNext >> 1);
      if (accept && isFull) ovfPend <= 1'b1;
      else if (doWrite)     ovfPend <= 1'b0;
    end
  end

  // ---------------- read domain ----------------
  logic [AW:0] rdBin, rdBinNext, rdGray, wrGrayA, wrGrayB, fillR;
  logic        lockA, running, runNext, justAdded, addNext, adv1, adv2;
  logic        selNext, rdOut;
  status_e     rdCode;

  always_comb begin
    fillR   = g2b(wrGrayB) - rdBin;
    runNext = running;
    addNext = justAdded;
    adv1    = 1'b0;
    adv2    = 1'b0;
    selNext = 1'b0;
    rdOut   = 1'b0;
    rdCode  = ST_GOOD;
    if (!rdLock) begin
      runNext = 1'b0;
    end else if (!running) begin
      if (fillR >= StartLvl) runNext = 1'b1;
    end else if (fillR == '0) begin
      if (!NOMINAL_EMPTY) begin
        rdCode  = ST_UNDERFLOW;
        runNext = 1'b0;
      end
    end else if (headSkp && (fillR > DropLvl)) begin
      rdOut   = 1'b1;
      selNext = 1'b1;
      adv2    = 1'b1;
      addNext = 1'b0;
      rdCode  = mergeCode(nextCode, ST_SKP_DEL);
    end else if (!NOMINAL_EMPTY && headSkp && (fillR < AddLvl) && !justAdded) begin
      rdOut   = 1'b1;
      addNext = 1'b1;
      rdCode  = mergeCode(headCode, ST_SKP_ADD);
    end else begin
      rdOut   = 1'b1;
      adv1    = 1'b1;
      addNext = 1'b0;
      rdCode  = headCode;
    end
    rdBinNext = rdBin + (AW+1)'({adv2, adv1});
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin     <= '0;
      rdGray    <= '0;
      wrGrayA   <= '0;
      wrGrayB   <= '0;
      lockA     <= 1'b0;
      rdLock    <= 1'b0;
      running   <= 1'b0;
      justAdded <= 1'b0;
    end else begin
      wrGrayA   <= wrGray;
      wrGrayB   <= wrGrayA;
      lockA     <= inLock;
      rdLock    <= lockA;
      running   <= runNext;
      justAdded <= addNext;
      rdBin     <= rdBinNext;
      rdGray    <= rdBinNext ^ (rdBinNext >> 1);
    end
  end

  assign wrAddr = wrBin[AW-1:0];
  assign rdAddr = rdBin[AW-1:0];

  always_comb begin
    str.wrEn     = doWrite;
    str.wrCode   = wrCode;
    str.selNext  = selNext;
    str.outValid = rdOut;
    str.outCode  = rdCode;
  end

endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
  import rx_elastic_buf_pkg::*;
#(
  parameter int         DEPTH_SYM      = 32,
  parameter int         START_SYM      = 16,
  parameter int         ADD_BELOW_SYM  = 12,
  parameter int         DROP_ABOVE_SYM = 20,
  parameter logic [7:0] SKP_SYM        = 8'h3C,
  parameter bit         NOMINAL_EMPTY  = 1'b0
) (
  input  logic        wrClk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLock,
  input  logic [15:0] inData,
  input  logic [1:0]  inK,
  input  logic [1:0]  inDecErr,
  input  logic [1:0]  inDispErr,
  input  logic        rdClk,
  output logic        outValid,
  output logic [15:0] outData,
  output logic [1:0]  outK,
  output logic [2:0]  outStatus
);

  localparam int DEPTH_W = DEPTH_SYM / 2;
  localparam int AW      = $clog2(DEPTH_W);
  localparam int START_W = NOMINAL_EMPTY ? 1 : START_SYM / 2;
  localparam int ADD_W   = ADD_BELOW_SYM / 2;
  localparam int DROP_W  = DROP_ABOVE_SYM / 2;

  strobe_t       str;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [AW:0]   wrFill;
  logic          rdLock, headSkp;
  status_e       headCode, nextCode;

  rx_elastic_buf_ctrl #(
    .DEPTH_W(DEPTH_W), .AW(AW), .START_W(START_W),
    .ADD_W(ADD_W), .DROP_W(DROP_W), .NOMINAL_EMPTY(NOMINAL_EMPTY)
  ) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .inValid(inValid), .inLock(inLock),
    .inDecErr(inDecErr), .inDispErr(inDispErr),
    .headSkp(headSkp), .headCode(headCode), .nextCode(nextCode),
    .str(str), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrFill(wrFill), .rdLock(rdLock)
  );

  rx_elastic_buf_dp #(
    .DEPTH_W(DEPTH_W), .AW(AW), .SKP_SYM(SKP_SYM)
  ) dp_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .inData(inData), .inK(inK), .str(str),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .headSkp(headSkp), .headCode(headCode), .nextCode(nextCode),
    .outValid(outValid), .outData(outData), .outK(outK), .outStatus(outStatus)
  );

endmodule

// File: rtl/rx_elastic_buf_chk.sv
module rx_elastic_buf_chk #(
  parameter int DEPTH_W       = 16,
  parameter int AW            = 4,
  parameter bit NOMINAL_EMPTY = 1'b0
) (
  input logic        wrClk,
  input logic        rdClk,
  input logic        rstN,
  input logic        outValid,
  input logic [2:0]  outStatus,
  input logic [AW:0] wrFill,
  input logic        rdLock
);

  AST_UNDERFLOW_NOT_VALID: assert property (@(posedge rdClk) disable iff (!rstN)
    (outStatus == 3'b110) |-> !outValid); // R9

  AST_IDLE_STATUS: assert property (@(posedge rdClk) disable iff (!rstN)
    !outValid |-> ((outStatus == 3'b000) || (outStatus == 3'b110))); // R10

  AST_VALID_AFTER_LOCK: assert property (@(posedge rdClk) disable iff (!rstN)
    outValid |-> $past(rdLock)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (!rstN)
    wrFill <= (AW+1)'(DEPTH_W)); // R8

  generate
    if (NOMINAL_EMPTY) begin : g_ne
      AST_NE_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (!rstN)
        outStatus != 3'b110); // R12
      AST_NE_NO_ADD: assert property (@(posedge rdClk) disable iff (!rstN)
        outStatus != 3'b001); // R12
    end
  endgenerate

endmodule

bind rx_elastic_buf rx_elastic_buf_chk #(
  .DEPTH_W(DEPTH_W), .AW(AW), .NOMINAL_EMPTY(NOMINAL_EMPTY)
) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .outValid(outValid), .outStatus(outStatus),
  .wrFill(wrFill), .rdLock(rdLock)
);

// File: tb/rx_elastic_buf_tb_top.sv
`timescale 1ns/1ps
module rx_elastic_buf_tb_top;

  logic        clk = 1'b0;
  logic        wrClk = 1'b0;
  realtime     wrHalf = 2.5;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inLock = 1'b0;
  logic [15:0] inData = '0;
  logic [1:0]  inK = '0, inDecErr = '0, inDispErr = '0;
  logic        outValid, neValid;
  logic [15:0] outData, neData;
  logic [1:0]  outK, neK;
  logic [2:0]  outStatus, neStatus;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  initial begin
    #1.2;
    forever #(wrHalf) wrClk = ~wrClk;
  end

  rx_elastic_buf dut_i (
    .wrClk(wrClk), .rstN(rstN), .inValid(inValid), .inLock(inLock),
    .inData(inData), .inK(inK), .inDecErr(inDecErr), .inDispErr(inDispErr),
    .rdClk(clk), .outValid(outValid), .outData(outData), .outK(outK),
    .outStatus(outStatus));

  rx_elastic_buf #(.NOMINAL_EMPTY(1'b1)) dutNe_i (
    .wrClk(wrClk), .rstN(rstN), .inValid(inValid), .inLock(inLock),
    .inData(inData), .inK(inK), .inDecErr(inDecErr), .inDispErr(inDispErr),
    .rdClk(clk), .outValid(neValid), .outData(neData), .outK(neK),
    .outStatus(neStatus));

  // ---------------- monitor ----------------
  logic        capOn = 1'b0;
  logic [15:0] capData [0:1023];
  logic [1:0]  capK    [0:1023];
  logic [2:0]  capCode [0:1023];
  int capN, unfIdle, badIdle, validUnf, neUnf, neAdd, neN;
  int cntCode [0:7];

  always @(negedge clk) begin
    if (capOn) begin
      if (outValid) begin
        if (capN < 1024) begin
          capData[capN] = outData;
          capK[capN]    = outK;
          capCode[capN] = outStatus;
        end
        capN++;
        cntCode[outStatus]++;
        if (outStatus == 3'b110) validUnf++;
      end else begin
        if (outStatus == 3'b110) unfIdle++;
        else if (outStatus != 3'b000) badIdle++;
      end
      if (neStatus == 3'b110) neUnf++;
      if (neValid && neStatus == 3'b001) neAdd++;
      if (neValid) neN++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit isSkp(input logic [15:0] d, input logic [1:0] k);
    return (k == 2'b11) && (d == 16'h3C3C);
  endfunction

  function automatic void genWord(input int i, input int skpMod,
                                  output logic [15:0] d, output logic [1:0] k);
    logic [7:0] lo;
    lo = i[7:0];
    if (skpMod > 0 && (i % skpMod) == skpMod - 1) begin
      d = 16'h3C3C;
      k = 2'b11;
    end else begin
      d = {~lo, lo};
      k = (i % 4 == 1) ? 2'b01 : (i % 4 == 2) ? 2'b10 : 2'b00;
    end
  endfunction

  task automatic doReset(input realtime half);
    capOn = 1'b0;
    rstN = 1'b0;
    inValid = 1'b0; inLock = 1'b0;
    inDecErr = '0; inDispErr = '0;
    wrHalf = half;
    repeat (4) @(posedge clk);
    capN = 0; unfIdle = 0; badIdle = 0; validUnf = 0;
    neUnf = 0; neAdd = 0; neN = 0;
    for (int c = 0; c < 8; c++) cntCode[c] = 0;
    #1 rstN = 1'b1;
    capOn = 1'b1;
  endtask

  // send n words; decIdx/dispIdx mark the words carrying errors (-1 for none)
  task automatic sendStream(input int n, input int skpMod, input logic lock,
                            input int decIdx, input int dispIdx, input int bothIdx);
    logic [15:0] d;
    logic [1:0]  k;
    inLock = lock;
    repeat (3) @(posedge wrClk);
    for (int i = 0; i < n; i++) begin
      @(posedge wrClk);
      #0.3;
      genWord(i, skpMod, d, k);
      inValid   = 1'b1;
      inData    = d;
      inK       = k;
      inDecErr  = (i == decIdx || i == bothIdx) ? 2'b01 : 2'b00;
      inDispErr = (i == dispIdx || i == bothIdx) ? 2'b10 : 2'b00;
    end
    @(posedge wrClk);
    #0.3;
    inValid = 1'b0; inDecErr = '0; inDispErr = '0;
    repeat (150) @(posedge clk);
  endtask

  // compare the delivered non-skip words against the sent ones
  task automatic checkOrder(input int n, input int skpMod, input string req,
                            output int skpOut, output int skpIn);
    logic [15:0] d;
    logic [1:0]  k;
    int cur = 0, bad = 0, firstAct = 0, firstExp = 0;
    skpOut = 0;
    skpIn = 0;
    for (int i = 0; i < n; i++) begin
      genWord(i, skpMod, d, k);
      if (isSkp(d, k)) begin
        skpIn++;
        continue;
      end
      while (cur < capN && cur < 1024 && isSkp(capData[cur], capK[cur])) begin
        skpOut++;
        cur++;
      end
      if (cur >= capN || cur >= 1024) begin
        bad++;
      end else if (capData[cur] != d || capK[cur] != k) begin
        if (bad == 0) begin
          firstAct = {14'd0, capK[cur], capData[cur]};
          firstExp = {14'd0, k, d};
        end
        bad++;
        cur++;
      end else begin
        cur++;
      end
    end
    while (cur < capN && cur < 1024 && isSkp(capData[cur], capK[cur])) begin
      skpOut++;
      cur++;
    end
    check(bad == 0, req, "non-skip word sequence (flags,data)", firstAct, firstExp);
    check(cur == capN, req, "no extra words delivered", capN, cur);
  endtask

  task automatic testReset;
    doReset(2.5);
    @(negedge clk);
    check(outValid == 1'b0, "R13", "outValid after reset", outValid, 0);
    check(outStatus == 3'b000, "R13", "status after reset", outStatus, 0);
  endtask

  task automatic testPass;
    int so, si, nonGood;
    doReset(2.5);
    sendStream(60, 0, 1'b1, -1, -1, -1);
    check(capN == 60, "R1", "word count at equal rates", capN, 60);
    checkOrder(60, 0, "R1 R2", so, si);
    nonGood = capN - cntCode[0];
    check(nonGood == 0, "R10", "good words carry 000", nonGood, 0);
    check(badIdle == 0, "R10", "idle cycles carry 000 or 110", badIdle, 0);
  endtask

  task automatic testLock;
    doReset(2.5);
    sendStream(20, 0, 1'b0, -1, -1, -1);
    check(capN == 0, "R3", "no delivery without lock", capN, 0);
    check(badIdle == 0 && unfIdle == 0, "R10", "idle status without lock",
          badIdle + unfIdle, 0);
  endtask

  task automatic testErrors;
    int others;
    doReset(2.5);
    sendStream(40, 0, 1'b1, 10, 20, 30);
    check(capN == 40, "R4", "word count with errors", capN, 40);
    check(capCode[10] == 3'b100, "R4", "decode error code", capCode[10], 4);
    check(capCode[20] == 3'b111, "R5", "disparity error code", capCode[20], 7);
    check(capCode[30] == 3'b100, "R11", "decode beats disparity", capCode[30], 4);
    others = capN - cntCode[0];
    check(others == 3, "R10", "only the error words are flagged", others, 3);
  endtask

  task automatic testRemove;
    int so, si;
    doReset(2.0);
    sendStream(300, 3, 1'b1, -1, -1, -1);
    check(cntCode[2] > 0, "R6", "skip removal reported", cntCode[2], 1);
    check(cntCode[5] == 0, "R6", "no overflow while removing", cntCode[5], 0);
    checkOrder(300, 3, "R6", so, si);
    check(so < si, "R6", "fewer skip words delivered than sent", so, si);
  endtask

  task automatic testAdd;
    int so, si;
    doReset(3.0);
    sendStream(300, 3, 1'b1, -1, -1, -1);
    check(cntCode[1] > 0, "R7", "skip addition reported", cntCode[1], 1);
    checkOrder(300, 3, "R7", so, si);
    check(so > si, "R7", "more skip words delivered than sent", so, si);
    check(neAdd == 0, "R12", "nominal-empty adds no skip", neAdd, 0);
  endtask

  task automatic testOverflow;
    doReset(2.0);
    sendStream(120, 0, 1'b1, -1, -1, -1);
    check(cntCode[5] > 0, "R8", "overflow code reported", cntCode[5], 1);
    check(capN < 120, "R8", "overflowed words discarded", capN, 119);
  endtask

  task automatic testUnderflow;
    doReset(3.0);
    sendStream(120, 0, 1'b1, -1, -1, -1);
    check(unfIdle > 0, "R9", "underflow code on idle cycle", unfIdle, 1);
    check(validUnf == 0, "R9", "underflow never on a valid word", validUnf, 0);
    check(capN == 120, "R9", "underflow loses no word", capN, 120);
    check(neUnf == 0, "R12", "nominal-empty never reports 110", neUnf, 0);
    check(neN == 120, "R12", "nominal-empty delivers all words", neN, 120);
  endtask

  initial begin
    #400us;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testPass();
    testLock();
    testErrors();
    testRemove();
    testAdd();
    testOverflow();
    testUnderflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule